// File: doc/BRIEF.md
# Weak-Ordering Memory Issue Gate

This block sits between an in-order stream of memory requests and a memory system that may finish those requests in any order. Each request carries one class bit that marks it as either a plain data access or a synchronization access. Data accesses pass the gate freely and may overlap one another up to a fixed limit. A synchronization access acts as an ordering point. It waits until every earlier data access has finished. While it is in flight, nothing behind it may issue.

The gate keeps two pieces of state. An up/down counter tracks how many data accesses are in flight. A two-state machine records whether a synchronization access is outstanding. The state `GATE_OPEN` means no synchronization access is in flight. The state `GATE_FENCED` means one is. The transition "sync issue" moves `GATE_OPEN` to `GATE_FENCED`. The transition "sync done" moves `GATE_FENCED` back to `GATE_OPEN` when memory reports a synchronization completion.

The request side is a valid/ready handshake and is strictly in order: a head request that cannot issue holds back everything behind it. An issue takes place in any cycle where `req_valid` and `req_ready` are both high. Memory reports completions as single-cycle pulses, each tagged with the class of the access that finished.

Top module: `wo_issue_gate`

## Requirements
- R1: After reset, `outstanding` is 0 and `fence_busy` is 0. A data request is then accepted at once.
- R2: A data request (`req_sync`=0) that issues without a counted data completion in the same cycle raises `outstanding` by one at the next clock edge.
- R3: A data completion (`cpl_valid`=1, `cpl_sync`=0) with no data issue in the same cycle lowers `outstanding` by one at the next edge. When `outstanding` is already 0, such a completion is ignored.
- R4: A data issue and a data completion in the same cycle leave `outstanding` unchanged.
- R5: A synchronization request (`req_sync`=1) sees `req_ready` high only when `outstanding` is 0 and the gate is open.
- R6: Once a synchronization request issues, `fence_busy` is high from the next cycle on. While `fence_busy` is high, `req_ready` stays low for both classes. The cycle after a synchronization completion (`cpl_valid`=1, `cpl_sync`=1), `fence_busy` is 0 and requests are accepted again.
- R7: When `outstanding` equals `MAX_OUT`, `req_ready` is low for data requests. The counter never exceeds `MAX_OUT`.
- R8: `iss_fire` equals `req_valid` AND `req_ready`, and `iss_sync` equals `req_sync` in that cycle. A head request that is not ready produces no issue.
- R9: A synchronization completion that arrives while the gate is open is ignored. Both `fence_busy` and `outstanding` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Head request present |
| req_sync | input | 1 | Class of head request: 1 = synchronization, 0 = data |
| req_ready | output | 1 | Gate accepts the head request this cycle |
| iss_fire | output | 1 | Request issues to memory this cycle |
| iss_sync | output | 1 | Class of the issuing request |
| cpl_valid | input | 1 | Completion pulse from memory |
| cpl_sync | input | 1 | Class of the completed access |
| outstanding | output | $clog2(MAX_OUT+1) | Data accesses in flight |
| fence_busy | output | 1 | A synchronization access is in flight |

## Verification
`req_ready`, `iss_fire` and `iss_sync` are combinational and are due in the same cycle as the inputs. The bench samples them one time step after driving the inputs on the falling edge. `outstanding` and `fence_busy` pass through one register each, so they are due after the next rising edge. The bench reads them on the following falling edge. A sweep puts the counter at every value from 0 to `MAX_OUT` and applies every combination of request and completion inputs at each value. The expected counts and ready values are computed arithmetically. A separate sequence holds the fence open and checks each cycle that it blocks requests and ignores stray completions.

// File: rtl/wo_gate_pkg.sv
package wo_gate_pkg;
    typedef enum logic {
        GATE_OPEN   = 1'b0,
        GATE_FENCED = 1'b1
    } gate_state_e;
endpackage

// File: rtl/wo_outstanding_ctr.sv
module wo_outstanding_ctr #(
    parameter int MAX_OUT = 4,
    parameter int CW      = $clog2(MAX_OUT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] count,
    output logic          at_zero,
    output logic          at_max
);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_OUT);

    logic dec_eff;

    // a completion with nothing in flight is dropped
    assign dec_eff = dec && (count != '0);
    assign at_zero = (count == '0);
    assign at_max  = (count == LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case ({inc, dec_eff})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/wo_fence_fsm.sv
module wo_fence_fsm
    import wo_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_issue,
    input  logic sync_done,
    output logic fence_busy
);
    gate_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_OPEN:   if (sync_issue) state_d = GATE_FENCED;
            GATE_FENCED: if (sync_done)  state_d = GATE_OPEN;
            default:     state_d = GATE_OPEN;
        endcase
    end

    always_comb begin
        fence_busy = (state_q == GATE_FENCED);
    end
endmodule

// File: rtl/wo_issue_decide.sv
module wo_issue_decide (
    input  logic req_valid,
    input  logic req_sync,
    input  logic fence_busy,
    input  logic cnt_zero,
    input  logic cnt_full,
    output logic req_ready,
    output logic fire,
    output logic data_fire,
    output logic sync_fire
);
    always_comb begin
        if (fence_busy)    req_ready = 1'b0;
        else if (req_sync) req_ready = cnt_zero;
        else               req_ready = !cnt_full;
        fire      = req_valid && req_ready;
        data_fire = fire && !req_sync;
        sync_fire = fire && req_sync;
    end
endmodule

// File: rtl/wo_issue_gate.sv
module wo_issue_gate #(
    parameter int MAX_OUT = 4,
    localparam int CW     = $clog2(MAX_OUT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_sync,
    output logic          req_ready,
    output logic          iss_fire,
    output logic          iss_sync,
    input  logic          cpl_valid,
    input  logic          cpl_sync,
    output logic [CW-1:0] outstanding,
    output logic          fence_busy
);
    logic cnt_zero, cnt_full, data_fire, sync_fire;
    logic data_cpl, sync_cpl;

    assign data_cpl = cpl_valid && !cpl_sync;
    assign sync_cpl = cpl_valid && cpl_sync;
    assign iss_sync = req_sync;

    wo_issue_decide u_decide (
        .req_valid (req_valid),
        .req_sync  (req_sync),
        .fence_busy(fence_busy),
        .cnt_zero  (cnt_zero),
        .cnt_full  (cnt_full),
        .req_ready (req_ready),
        .fire      (iss_fire),
        .data_fire (data_fire),
        .sync_fire (sync_fire)
    );

    wo_outstanding_ctr #(.MAX_OUT(MAX_OUT), .CW(CW)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (data_fire),
        .dec    (data_cpl),
        .count  (outstanding),
        .at_zero(cnt_zero),
        .at_max (cnt_full)
    );

    wo_fence_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_issue(sync_fire),
        .sync_done (sync_cpl),
        .fence_busy(fence_busy)
    );
endmodule

// File: rtl/wo_gate_chk.sv
module wo_gate_chk #(
    parameter int MAX_OUT = 4,
    parameter int CW      = $clog2(MAX_OUT + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_sync,
    input logic          req_ready,
    input logic          iss_fire,
    input logic          cpl_valid,
    input logic          cpl_sync,
    input logic [CW-1:0] outstanding,
    input logic          fence_busy
);
    logic dcpl_counted;
    assign dcpl_counted = cpl_valid && !cpl_sync && (outstanding != '0);

    // R2
    data_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_fire && !req_sync && !dcpl_counted) |=> outstanding == CW'($past(outstanding) + 1'b1));
    // R3
    data_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(iss_fire && !req_sync) && dcpl_counted) |=> outstanding == CW'($past(outstanding) - 1'b1));
    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_fire && !req_sync && dcpl_counted) |=> $stable(outstanding));
    // R5
    sync_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_fire && req_sync) |-> (outstanding == '0));
    // R6
    fence_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fence_busy |-> !req_ready);
    // R6
    fence_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_fire && req_sync) |=> fence_busy);
    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding <= CW'(MAX_OUT));
    // R8
    fire_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_fire |-> (req_valid && req_ready));
    // R9
    stray_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fence_busy && !iss_fire && cpl_valid && cpl_sync) |=> !fence_busy);
endmodule

bind wo_issue_gate wo_gate_chk #(.MAX_OUT(MAX_OUT), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_sync   (req_sync),
    .req_ready  (req_ready),
    .iss_fire   (iss_fire),
    .cpl_valid  (cpl_valid),
    .cpl_sync   (cpl_sync),
    .outstanding(outstanding),
    .fence_busy (fence_busy)
);

// File: tb/tb_wo_issue_gate.sv
module tb_wo_issue_gate;
    localparam int MAX_OUT = 4;
    localparam int CW = $clog2(MAX_OUT + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_sync = 1'b0, cpl_valid = 1'b0, cpl_sync = 1'b0;
    logic req_ready, iss_fire, iss_sync, fence_busy;
    logic [CW-1:0] outstanding;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wo_issue_gate #(.MAX_OUT(MAX_OUT)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_sync(req_sync), .req_ready(req_ready),
        .iss_fire(iss_fire), .iss_sync(iss_sync),
        .cpl_valid(cpl_valid), .cpl_sync(cpl_sync),
        .outstanding(outstanding), .fence_busy(fence_busy)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 0; req_sync = 0; cpl_valid = 0; cpl_sync = 0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // drive at falling edge, one clock, inputs cleared at next falling edge
    task automatic step(input bit v, input bit s, input bit cv, input bit cs);
        req_valid = v; req_sync = s; cpl_valid = cv; cpl_sync = cs;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0; req_sync = 0; cpl_valid = 0; cpl_sync = 0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1
        check("R1 outstanding", int'(outstanding), 0);
        check("R1 fence_busy", int'(fence_busy), 0);
        req_valid = 1; req_sync = 0; #1;
        check("R1 ready", int'(req_ready), 1);
        req_valid = 0;

        // sweep every count and every input combination
        for (int k = 0; k <= MAX_OUT; k++) begin
            for (int c = 0; c < 16; c++) begin
                bit v, s, cv, cs, rdy, dfire, dcpl, sfire;
                int nxt;
                v = c[3]; s = c[2]; cv = c[1]; cs = c[0];
                do_reset();
                for (int i = 0; i < k; i++) step(1, 0, 0, 0);
                check("R2 setup count", int'(outstanding), k);
                rdy   = s ? (k == 0) : (k < MAX_OUT);
                dfire = v && rdy && !s;
                sfire = v && rdy && s;
                dcpl  = cv && !cs && (k > 0);
                nxt   = k + int'(dfire) - int'(dcpl);
                req_valid = v; req_sync = s; cpl_valid = cv; cpl_sync = cs;
                #1;
                if (s) check("R5 sync ready", int'(req_ready), int'(rdy));
                else   check("R7 data ready", int'(req_ready), int'(rdy));
                check("R8 fire", int'(iss_fire), int'(v && rdy));
                check("R8 iss_sync", int'(iss_sync), int'(s));
                @(posedge clk);
                @(negedge clk);
                req_valid = 0; req_sync = 0; cpl_valid = 0; cpl_sync = 0;
                if (dfire && dcpl)      check("R4 hold", int'(outstanding), nxt);
                else if (dcpl)          check("R3 dec", int'(outstanding), nxt);
                else if (cv && !cs)     check("R3 ignore at zero", int'(outstanding), nxt);
                else                    check("R2 count", int'(outstanding), nxt);
                if (!sfire && cv && cs) check("R9 stray sync cpl", int'(fence_busy), 0);
                else                    check("R6 fence set", int'(fence_busy), int'(sfire));
            end
        end

        // fence window
        do_reset();
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        req_valid = 1; req_sync = 1; #1;
        check("R5 sync blocked by data", int'(req_ready), 0);
        req_valid = 0; req_sync = 0;
        step(0, 0, 1, 0);
        step(0, 0, 1, 0);
        check("R3 drained", int'(outstanding), 0);
        step(1, 1, 0, 0);
        check("R6 fenced", int'(fence_busy), 1);
        for (int t = 0; t < 5; t++) begin
            req_valid = 1; req_sync = t[0]; #1;
            check("R6 blocked", int'(req_ready), 0);
            check("R8 no fire while blocked", int'(iss_fire), 0);
            cpl_valid = 1; cpl_sync = 0;
            @(posedge clk);
            @(negedge clk);
            cpl_valid = 0;
            check("R6 count frozen", int'(outstanding), 0);
            check("R6 still fenced", int'(fence_busy), 1);
        end
        req_valid = 0; req_sync = 0;
        step(0, 0, 1, 1);
        check("R6 released", int'(fence_busy), 0);
        req_valid = 1; req_sync = 0; #1;
        check("R6 ready after release", int'(req_ready), 1);
        req_valid = 0;

        // saturation then overlapped completion
        do_reset();
        for (int i = 0; i < MAX_OUT + 2; i++) step(1, 0, 0, 0);
        check("R7 saturated", int'(outstanding), MAX_OUT);
        step(1, 0, 1, 0);
        check("R7 stall then dec", int'(outstanding), MAX_OUT - 1);
        step(1, 0, 1, 0);
        check("R4 overlap", int'(outstanding), MAX_OUT - 1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule